// File: doc/BRIEF.md
# Tag-Guarded Scratch Memory

This block is a small byte-addressed data memory whose every access is screened by a lock-and-key test. The memory is divided into 16-byte granules, and each granule owns a 4-bit lock value held in a separate tag file. A 64-bit pointer carries its key in bits [59:56]. A load or store goes through only when the key equals the lock of every granule the access touches. An allocator programs locks through a plain command port. It writes a chosen value when it hands a granule out and writes zero when the granule is given back. After that, any pointer still carrying the old key is refused.

Loads and stores arrive on a valid/ready request channel and finish on a valid/ready response channel. A request is taken on any rising edge where `req_valid` and `req_ready` are both high. Its response appears on the next edge. The block holds one response: while `rsp_valid` is high and `rsp_ready` is low, the response is frozen and `req_ready` stays low. A refused access is fatal. The store does not happen, the load returns zero, and a fault record latches. From then on the block accepts no further requests until reset.

Top module: `tag_guard_mem`

## Requirements
- R1: The key is pointer bits [59:56], and the granule index is physical byte address bits [7:4]. An access goes through only when the key equals the lock of each granule it touches.
- R2: A set command (`tcmd_en`=1, `tcmd_clear`=0) writes `tcmd_tag` into the lock of granule `tcmd_gran`. Later accesses carrying that key go through: stores update memory and loads return the stored bytes.
- R3: A clear command (`tcmd_en`=1, `tcmd_clear`=1) writes lock 0 whatever `tcmd_tag` holds. A pointer still carrying the previous nonzero key is then refused.
- R4: Reset sets every lock to 0, the untagged value, and leaves data contents intact. An untagged granule admits only key 0.
- R5: A refused store leaves memory unchanged. A refused load or store responds with `rsp_denied`=1 and `rsp_data`=0.
- R6: The first refusal raises `flt_valid` and latches the full pointer, the key and the mismatching lock (the first granule's lock if that one mismatches, else the second's). `flt_valid` and the record then hold until reset, and `req_ready` stays 0.
- R7: Pointer bits above bit 7, including the key bits, do not take part in forming the physical address.
- R8: A 4-byte access spanning two granules is checked against both locks, and a mismatch on either one refuses it.
- R9: Locks may repeat. A pointer whose key equals the lock of a different granule reaches that granule.
- R10: `rsp_valid` rises on the edge after a request is taken. While `rsp_ready` is low, the response stays valid and unchanged and `req_ready` stays 0.
- R11: Data is little-endian. The byte at the pointer's address is `rsp_data[7:0]`, and the next three ascending addresses (modulo 256) fill the higher bytes.
- R12: A lock command issued in the same cycle as an accepted access takes effect after that access. The access is checked against the lock value held before the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tcmd_en | input | 1 | Lock command strobe |
| tcmd_clear | input | 1 | 1: write lock 0; 0: write tcmd_tag |
| tcmd_gran | input | 4 | Granule index for the lock command |
| tcmd_tag | input | 4 | Lock value for a set command |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1: store, 0: load |
| req_addr | input | 64 | Keyed pointer |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 32 | Load data, zero on refusal or store |
| rsp_denied | output | 1 | Access was refused |
| flt_valid | output | 1 | Sticky fault flag |
| flt_addr | output | 64 | Pointer of the first refused access |
| flt_ptr_tag | output | 4 | Key of the first refused access |
| flt_mem_tag | output | 4 | Mismatching lock of the first refused access |

## Verification
The bound properties watch the channel and fault rules on every cycle. They check that a response follows each accepted request and stays frozen under back-pressure. They check that a refused response carries zero data, that the fault record never changes once raised, and that a raised fault blocks further requests. Which accesses pass and which fail depends on lock contents, so only the bench scenarios can show it. These cover set, clear and reused locks, keys on accesses that straddle granules, and a lock command that collides with an access. Whether a refused store left memory alone is read back after reset.

// File: rtl/tgm_pkg.sv
package tgm_pkg;
  localparam int TAG_W = 4;
  localparam logic [TAG_W-1:0] TAG_NONE = '0;

  typedef struct packed {
    logic             pass;
    logic [TAG_W-1:0] bad_tag;
  } tag_verdict_t;
endpackage

// File: rtl/tgm_tag_store.sv
module tgm_tag_store
  import tgm_pkg::*;
#(
  parameter int NUM_GRAN = 16,
  localparam int GIDX_W = $clog2(NUM_GRAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [GIDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [GIDX_W-1:0] rd_idx_a,
  input  logic [GIDX_W-1:0] rd_idx_b,
  output logic [TAG_W-1:0]  rd_tag_a,
  output logic [TAG_W-1:0]  rd_tag_b
);
  logic [TAG_W-1:0] locks [NUM_GRAN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_GRAN; i++) locks[i] <= TAG_NONE;
    end else if (wr_en) begin
      locks[wr_idx] <= wr_tag;
    end
  end

  assign rd_tag_a = locks[rd_idx_a];
  assign rd_tag_b = locks[rd_idx_b];
endmodule

// File: rtl/tgm_tag_check.sv
module tgm_tag_check
  import tgm_pkg::*;
(
  input  logic [TAG_W-1:0] key,
  input  logic [TAG_W-1:0] lock_lo,
  input  logic [TAG_W-1:0] lock_hi,
  output tag_verdict_t     verdict
);
  logic lo_ok, hi_ok;

  always_comb begin
    lo_ok = (key == lock_lo);
    hi_ok = (key == lock_hi);
    verdict.pass    = lo_ok && hi_ok;
    verdict.bad_tag = lo_ok ? lock_hi : lock_lo;
  end
endmodule

// File: rtl/tgm_byte_mem.sv
module tgm_byte_mem #(
  parameter int MEM_BYTES = 256,
  parameter int LANES     = 4,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic               clk,
  input  logic [AW-1:0]      addr,
  input  logic               wr_en,
  input  logic [8*LANES-1:0] wdata,
  output logic [8*LANES-1:0] rdata
);
  logic [7:0] bytes_q [MEM_BYTES];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < LANES; l++) bytes_q[addr + AW'(l)] <= wdata[8*l +: 8];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rdata[8*g +: 8] = bytes_q[addr + AW'(g)];
  end
endmodule

// File: rtl/tag_guard_mem.sv
module tag_guard_mem
  import tgm_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int DATA_W     = 32,
  parameter int MEM_BYTES  = 256,
  parameter int GRAN_BYTES = 16,
  parameter int KEY_LSB    = 56,
  localparam int NUM_GRAN  = MEM_BYTES / GRAN_BYTES,
  localparam int GIDX_W    = $clog2(NUM_GRAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tcmd_en,
  input  logic              tcmd_clear,
  input  logic [GIDX_W-1:0] tcmd_gran,
  input  logic [TAG_W-1:0]  tcmd_tag,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_denied,
  output logic              flt_valid,
  output logic [ADDR_W-1:0] flt_addr,
  output logic [TAG_W-1:0]  flt_ptr_tag,
  output logic [TAG_W-1:0]  flt_mem_tag
);
  localparam int ACC_BYTES = DATA_W / 8;
  localparam int PHYS_W    = $clog2(MEM_BYTES);
  localparam int GRAN_SH   = $clog2(GRAN_BYTES);

  logic [PHYS_W-1:0] first_byte, last_byte;
  logic [GIDX_W-1:0] gran_lo, gran_hi;
  logic [TAG_W-1:0]  key, lock_lo, lock_hi, new_lock;
  logic [DATA_W-1:0] mem_rdata;
  tag_verdict_t      verdict;
  logic              take, store_ok;

  assign first_byte = req_addr[PHYS_W-1:0];
  assign last_byte  = first_byte + PHYS_W'(ACC_BYTES - 1);
  assign gran_lo    = first_byte[PHYS_W-1:GRAN_SH];
  assign gran_hi    = last_byte[PHYS_W-1:GRAN_SH];
  assign key        = req_addr[KEY_LSB +: TAG_W];
  assign new_lock   = tcmd_clear ? TAG_NONE : tcmd_tag;

  assign req_ready = !flt_valid && (!rsp_valid || rsp_ready);
  assign take      = req_valid && req_ready;
  assign store_ok  = take && req_write && verdict.pass;

  tgm_tag_store #(.NUM_GRAN(NUM_GRAN)) u_locks (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tcmd_en),
    .wr_idx   (tcmd_gran),
    .wr_tag   (new_lock),
    .rd_idx_a (gran_lo),
    .rd_idx_b (gran_hi),
    .rd_tag_a (lock_lo),
    .rd_tag_b (lock_hi)
  );

  tgm_tag_check u_check (
    .key     (key),
    .lock_lo (lock_lo),
    .lock_hi (lock_hi),
    .verdict (verdict)
  );

  tgm_byte_mem #(.MEM_BYTES(MEM_BYTES), .LANES(ACC_BYTES)) u_mem (
    .clk   (clk),
    .addr  (first_byte),
    .wr_en (store_ok),
    .wdata (req_wdata),
    .rdata (mem_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_denied <= 1'b0;
    end else if (take) begin
      rsp_valid  <= 1'b1;
      rsp_denied <= !verdict.pass;
      rsp_data   <= (verdict.pass && !req_write) ? mem_rdata : '0;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_valid   <= 1'b0;
      flt_addr    <= '0;
      flt_ptr_tag <= TAG_NONE;
      flt_mem_tag <= TAG_NONE;
    end else if (take && !verdict.pass) begin
      flt_valid   <= 1'b1;
      flt_addr    <= req_addr;
      flt_ptr_tag <= key;
      flt_mem_tag <= verdict.bad_tag;
    end
  end
endmodule

// File: rtl/tgm_props.sv
module tgm_props #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32,
  parameter int TW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_denied,
  input logic              flt_valid,
  input logic [ADDR_W-1:0] flt_addr,
  input logic [TW-1:0]     flt_ptr_tag,
  input logic [TW-1:0]     flt_mem_tag
);
  // R10
  resp_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R10
  resp_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_denied));

  // R10
  backpressure_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  // R5
  refused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_denied |-> rsp_data == '0);

  // R6
  fault_record_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> flt_valid && $stable(flt_addr) && $stable(flt_ptr_tag) && $stable(flt_mem_tag));

  // R6
  fault_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> !req_ready);

  // R6
  fault_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_valid) |-> rsp_valid && rsp_denied);
endmodule

bind tag_guard_mem tgm_props #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TW(tgm_pkg::TAG_W)) props_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_data    (rsp_data),
  .rsp_denied  (rsp_denied),
  .flt_valid   (flt_valid),
  .flt_addr    (flt_addr),
  .flt_ptr_tag (flt_ptr_tag),
  .flt_mem_tag (flt_mem_tag)
);

// File: tb/tag_guard_mem_tb_top.sv
`timescale 1ns/1ps
module tag_guard_mem_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tcmd_en = 1'b0, tcmd_clear = 1'b0;
  logic [3:0]  tcmd_gran = '0, tcmd_tag = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [63:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ready = 1'b1;
  logic        req_ready, rsp_valid, rsp_denied, flt_valid;
  logic [31:0] rsp_data;
  logic [63:0] flt_addr;
  logic [3:0]  flt_ptr_tag, flt_mem_tag;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  logic [31:0] q_data [$];
  bit          q_den  [$];
  string       q_req  [$];

  always #2 clk = ~clk;

  tag_guard_mem dut_i (
    .clk(clk), .rst_n(rst_n),
    .tcmd_en(tcmd_en), .tcmd_clear(tcmd_clear), .tcmd_gran(tcmd_gran), .tcmd_tag(tcmd_tag),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_denied(rsp_denied),
    .flt_valid(flt_valid), .flt_addr(flt_addr), .flt_ptr_tag(flt_ptr_tag), .flt_mem_tag(flt_mem_tag)
  );

  function automatic logic [63:0] ptr(input logic [3:0] key, input logic [7:0] a);
    return {4'h0, key, 48'h0, a};
  endfunction

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each completed response handshake
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (q_data.size() == 0) begin
        check(1'b0, "R10 unexpected response", {32'h0, rsp_data}, 64'h0);
      end else begin
        logic [31:0] ed;
        bit          en;
        string       rq;
        ed = q_data.pop_front();
        en = q_den.pop_front();
        rq = q_req.pop_front();
        check(rsp_data == ed, rq, {32'h0, rsp_data}, {32'h0, ed});
        check(rsp_denied == en, {rq, " denied"}, {63'h0, rsp_denied}, {63'h0, en});
      end
    end
  end

  task automatic access(input bit wr, input logic [63:0] a, input logic [31:0] wd,
                        input logic [31:0] exp_d, input bit exp_den, input string rq);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    while (!req_ready) begin @(posedge clk); #1; end
    q_data.push_back(exp_d); q_den.push_back(exp_den); q_req.push_back(rq);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic lock_cmd(input bit clr, input logic [3:0] g, input logic [3:0] t);
    @(posedge clk); #1;
    tcmd_en = 1'b1; tcmd_clear = clr; tcmd_gran = g; tcmd_tag = t;
    @(posedge clk); #1;
    tcmd_en = 1'b0;
  endtask

  task automatic drain();
    while (q_data.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic check_fault(input logic [63:0] a, input logic [3:0] k, input logic [3:0] lk, input string rq);
    @(negedge clk);
    check(flt_valid == 1'b1, {rq, " fault flag"}, {63'h0, flt_valid}, 64'h1);
    check(flt_addr == a, {rq, " fault addr"}, flt_addr, a);
    check(flt_ptr_tag == k, {rq, " fault key"}, {60'h0, flt_ptr_tag}, {60'h0, k});
    check(flt_mem_tag == lk, {rq, " fault lock"}, {60'h0, flt_mem_tag}, {60'h0, lk});
    repeat (3) @(negedge clk);
    check(req_ready == 1'b0 && flt_valid, {rq, " fail-stop"}, {62'h0, req_ready, flt_valid}, 64'h1);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // Reset state (R4, R6)
    check(req_ready == 1'b1, "R4 reset ready", {63'h0, req_ready}, 64'h1);
    check(flt_valid == 1'b0, "R6 reset fault clear", {63'h0, flt_valid}, 64'h0);
    check(rsp_valid == 1'b0, "R10 reset no response", {63'h0, rsp_valid}, 64'h0);

    // R4: untagged granules admit key 0; R11 byte order
    access(1, ptr(0, 8'h00), 32'h11223344, 32'h0, 0, "R4 store untagged");
    access(1, ptr(0, 8'h04), 32'h55667788, 32'h0, 0, "R4 store untagged 2");
    access(0, ptr(0, 8'h00), 32'h0, 32'h11223344, 0, "R4 load untagged");
    access(0, ptr(0, 8'h01), 32'h0, 32'h88112233, 0, "R11 unaligned little-endian");

    // R2: set lock, R7 upper bits ignored
    lock_cmd(0, 4'd2, 4'd5);
    access(1, ptr(5, 8'h20), 32'hCAFEF00D, 32'h0, 0, "R2 store with key");
    access(0, ptr(5, 8'h20), 32'h0, 32'hCAFEF00D, 0, "R2 load with key");
    access(0, ptr(5, 8'h20) | 64'hF000_0100_0000_0000, 32'h0, 32'hCAFEF00D, 0, "R7 high bits ignored");

    // R9: lock value reused in granule 3
    lock_cmd(0, 4'd3, 4'd5);
    access(1, ptr(5, 8'h30), 32'h0BADBEEF, 32'h0, 0, "R9 reused lock store");
    access(1, ptr(5, 8'h2C), 32'hA1B2C3D4, 32'h0, 0, "R9 store granule 2");
    // R8: straddle, both locks match
    access(0, ptr(5, 8'h2E), 32'h0, 32'hBEEFA1B2, 0, "R8 straddle both match");

    // R12: lock change in the same cycle as an access
    drain();
    @(posedge clk); #1;
    tcmd_en = 1'b1; tcmd_clear = 1'b0; tcmd_gran = 4'd2; tcmd_tag = 4'hA;
    req_valid = 1'b1; req_write = 1'b0; req_addr = ptr(5, 8'h20);
    q_data.push_back(32'hCAFEF00D); q_den.push_back(1'b0); q_req.push_back("R12 old lock applies");
    @(posedge clk); #1;
    tcmd_en = 1'b0; req_valid = 1'b0;
    access(0, ptr(4'hA, 8'h20), 32'h0, 32'hCAFEF00D, 0, "R12 new lock after");

    // R10: back-pressure
    drain();
    @(posedge clk); #1 rsp_ready = 1'b0;
    access(0, ptr(0, 8'h00), 32'h0, 32'h11223344, 0, "R10 held response");
    repeat (3) begin
      @(negedge clk);
      check(rsp_valid && !req_ready, "R10 stall while held", {62'h0, rsp_valid, req_ready}, 64'h2);
    end
    @(posedge clk); #1 rsp_ready = 1'b1;
    drain();

    // R3: clear then stale key refused; R5 refused load returns zero
    lock_cmd(1, 4'd3, 4'd7);
    access(0, ptr(5, 8'h30), 32'h0, 32'h0, 1, "R3 stale key refused");
    drain();
    check_fault(ptr(5, 8'h30), 4'd5, 4'd0, "R6 stale");
    do_reset();
    access(0, ptr(0, 8'h30), 32'h0, 32'h0BADBEEF, 0, "R4 data survives reset");

    // R5: refused store leaves memory unchanged
    lock_cmd(0, 4'd1, 4'd3);
    access(1, ptr(3, 8'h10), 32'h01020304, 32'h0, 0, "R5 good store");
    access(1, ptr(4, 8'h10), 32'hFFFFFFFF, 32'h0, 1, "R5 refused store");
    drain();
    check_fault(ptr(4, 8'h10), 4'd4, 4'd3, "R1 mismatch");
    do_reset();
    access(0, ptr(0, 8'h10), 32'h0, 32'h01020304, 0, "R5 memory unchanged");

    // R8: straddle with second lock mismatching
    lock_cmd(0, 4'd4, 4'd7);
    lock_cmd(0, 4'd5, 4'd9);
    access(0, ptr(7, 8'h4E), 32'h0, 32'h0, 1, "R8 second granule refuses");
    drain();
    check_fault(ptr(7, 8'h4E), 4'd7, 4'd9, "R8 straddle");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule